// File: doc/BRIEF.md
# UART Status Flag Controller

This block holds the status flags and the interrupt request logic of a serial transmit/receive unit. It sits between a CPU register bus and the transmit and receive shift registers. Events from the shifters set flags in an 8-bit status word. Software clears those flags only with a two-step access: first a read of the status register, then an access to the data register. A data write clears the transmit flags and a data read clears the receive flags.

The block also decides when the held transmit byte may move into an idle transmit shifter. It tells the data path when a received byte may be captured, and records an overrun instead when the previous byte has not been collected yet. The flags that are set and enabled are combined into one level-sensitive interrupt line, which a global mask can block.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status word is 0xC0: transmit-empty and transmit-complete are set, and every other flag is clear.
- R2: Status bit positions, MSB first, are: 7 transmit-empty, 6 transmit-complete, 5 receive-ready, 4 line-idle, 3 overrun, 2 noise, 1 framing error, 0 parity error.
- R3: Transmit-empty and transmit-complete are cleared only by a data-register write (address 1) that comes after a status-register read (address 0). A data write with no status read before it leaves them unchanged.
- R4: A status read arms exactly one data-register access. Any data read or data write disarms it, so a later data write with no new status read clears nothing.
- R5: `load_shifter_o` is high only while transmit-empty is clear and `tx_idle_i` is high. Transmit-empty is set on the next cycle. No load happens while the shifter is busy.
- R6: A finished frame of kind data (`frame_kind_i` = 0) sets transmit-complete. Kind preamble (1) and kind break (2) do not set it.
- R7: A received byte that arrives while receive-ready is clear pulses `rx_capture_o` in the same cycle. On the next cycle receive-ready is set and the noise, framing and parity flags take the values of that byte's error inputs.
- R8: A received byte that arrives while receive-ready is already set raises no capture. It sets overrun, and receive-ready and the existing error flags are kept.
- R9: Receive-ready, line-idle, overrun, noise, framing and parity are cleared by a data-register read after a status read.
- R10: When a flag is set and cleared in the same cycle, the set wins.
- R11: `irq_o` is the OR of these terms: enable bit 4 with transmit-empty, bit 3 with transmit-complete, bit 2 with (receive-ready or overrun), bit 1 with line-idle, and bit 0 with parity. The result is forced low while `irq_mask_i` is high. Noise and framing raise no interrupt.
- R12: A pulse on `rx_idle_i` sets line-idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (0 status, 1 data) |
| tx_idle_i | input | 1 | Transmit shifter can accept a byte |
| tx_frame_done_i | input | 1 | Transmit shifter finished a frame |
| frame_kind_i | input | 2 | Kind of the finished frame: 0 data, 1 preamble, 2 break |
| rx_byte_done_i | input | 1 | Receive shifter holds a complete byte |
| rx_noise_i | input | 1 | Noise seen on that byte |
| rx_frame_err_i | input | 1 | Stop bit missing on that byte |
| rx_parity_err_i | input | 1 | Parity mismatch on that byte |
| rx_idle_i | input | 1 | Idle line detected |
| int_en_i | input | 5 | Interrupt enables: 4 tx-empty, 3 tx-complete, 2 rx-ready/overrun, 1 idle, 0 parity |
| irq_mask_i | input | 1 | Global interrupt mask, high blocks |
| status_o | output | 8 | Status word readback |
| load_shifter_o | output | 1 | Move the held transmit byte into the shifter |
| rx_capture_o | output | 1 | Move the received byte into the data register |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bound checker watches several rules on every cycle. Transmit-empty may rise only through a shifter load and may fall only right after a data write. Receive-ready may fall only right after a data read. A preamble or break frame never raises transmit-complete. A byte arriving while receive-ready is set always raises overrun. The interrupt stays low while it is masked and while no flag that can interrupt is set. The bench alone shows the ordering rules of the access sequence: a data write with no status read before it, and an arming used up by a data read. It also checks set-over-clear collisions, exact status values, and the full table of enables and mask against several flag patterns.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    typedef struct packed {
        logic tdre;   // bit 7 transmit-empty
        logic tc;     // bit 6 transmit-complete
        logic rdrf;   // bit 5 receive-ready
        logic idle;   // bit 4 line idle
        logic ovr;    // bit 3 overrun
        logic noise;  // bit 2 noise
        logic ferr;   // bit 1 framing
        logic perr;   // bit 0 parity
    } flags_t;

    typedef enum logic [1:0] {
        FRM_DATA     = 2'b00,
        FRM_PREAMBLE = 2'b01,
        FRM_BREAK    = 2'b10,
        FRM_RSVD     = 2'b11
    } frame_t;

    typedef struct packed {
        logic tx_empty;
        logic tx_done;
        logic rx_ready;
        logic line_idle;
        logic parity;
    } irq_en_t;

    typedef struct packed {
        logic noise;
        logic ferr;
        logic perr;
    } rx_err_t;

    localparam logic [7:0] FLAGS_RESET = 8'hC0;

    function automatic logic frame_sets_tc(frame_t kind);
        return kind == FRM_DATA;
    endfunction

endpackage

// File: rtl/ufc_access_seq.sv
module ufc_access_seq #(
    parameter int ADDR_W = 1,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              clr_tx,
    output logic              clr_rx
);
    logic armed_q;
    logic status_rd;
    logic data_acc;

    assign status_rd = rd && (addr == STATUS_ADDR);
    assign data_acc  = (rd || wr) && (addr == DATA_ADDR);
    assign clr_tx    = armed_q && wr && (addr == DATA_ADDR);
    assign clr_rx    = armed_q && rd && (addr == DATA_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (data_acc)
            armed_q <= 1'b0;
        else if (status_rd)
            armed_q <= 1'b1;
    end
endmodule

// File: rtl/ufc_tx_flags.sv
module ufc_tx_flags
    import uart_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   tx_idle,
    input  logic   frame_done,
    input  frame_t frame_kind,
    output logic   tdre,
    output logic   tc,
    output logic   load
);
    logic tdre_q, tc_q;
    logic tc_set;

    assign load   = !tdre_q && tx_idle;
    assign tc_set = frame_done && frame_sets_tc(frame_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            tdre_q <= FLAGS_RESET[7];
            tc_q   <= FLAGS_RESET[6];
        end else begin
            tdre_q <= load   || (tdre_q && !clr);
            tc_q   <= tc_set || (tc_q   && !clr);
        end
    end

    assign tdre = tdre_q;
    assign tc   = tc_q;
endmodule

// File: rtl/ufc_rx_flags.sv
module ufc_rx_flags
    import uart_flag_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    byte_done,
    input  rx_err_t err_in,
    input  logic    idle_det,
    output logic    rdrf,
    output logic    idle,
    output logic    ovr,
    output rx_err_t err,
    output logic    capture
);
    logic    rdrf_q, idle_q, ovr_q;
    rx_err_t err_q;
    logic    overrun_ev;

    assign capture    = byte_done && !rdrf_q;
    assign overrun_ev = byte_done && rdrf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdrf_q <= 1'b0;
            idle_q <= 1'b0;
            ovr_q  <= 1'b0;
            err_q  <= '0;
        end else begin
            rdrf_q <= byte_done  || (rdrf_q && !clr);
            idle_q <= idle_det   || (idle_q && !clr);
            ovr_q  <= overrun_ev || (ovr_q  && !clr);
            err_q  <= (capture ? err_in : '0) | (clr ? '0 : err_q);
        end
    end

    assign rdrf = rdrf_q;
    assign idle = idle_q;
    assign ovr  = ovr_q;
    assign err  = err_q;
endmodule

// File: rtl/ufc_irq_comb.sv
module ufc_irq_comb
    import uart_flag_pkg::*;
(
    input  flags_t  flags,
    input  irq_en_t en,
    input  logic    mask,
    output logic    irq
);
    logic [4:0] req;

    always_comb begin
        req[4] = en.tx_empty  && flags.tdre;
        req[3] = en.tx_done   && flags.tc;
        req[2] = en.rx_ready  && (flags.rdrf || flags.ovr);
        req[1] = en.line_idle && flags.idle;
        req[0] = en.parity    && flags.perr;
        irq    = !mask && (|req);
    end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uart_flag_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              tx_idle_i,
    input  logic              tx_frame_done_i,
    input  logic [1:0]        frame_kind_i,
    input  logic              rx_byte_done_i,
    input  logic              rx_noise_i,
    input  logic              rx_frame_err_i,
    input  logic              rx_parity_err_i,
    input  logic              rx_idle_i,
    input  logic [4:0]        int_en_i,
    input  logic              irq_mask_i,
    output logic [7:0]        status_o,
    output logic              load_shifter_o,
    output logic              rx_capture_o,
    output logic              irq_o
);
    logic    clr_tx, clr_rx;
    flags_t  flags;
    rx_err_t err_in, err_q;

    assign err_in = '{noise: rx_noise_i, ferr: rx_frame_err_i, perr: rx_parity_err_i};

    ufc_access_seq #(
        .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_seq (
        .clk(clk), .rst(rst), .rd(reg_rd_i), .wr(reg_wr_i), .addr(reg_addr_i),
        .clr_tx(clr_tx), .clr_rx(clr_rx)
    );

    ufc_tx_flags u_tx (
        .clk(clk), .rst(rst), .clr(clr_tx), .tx_idle(tx_idle_i),
        .frame_done(tx_frame_done_i), .frame_kind(frame_t'(frame_kind_i)),
        .tdre(flags.tdre), .tc(flags.tc), .load(load_shifter_o)
    );

    ufc_rx_flags u_rx (
        .clk(clk), .rst(rst), .clr(clr_rx), .byte_done(rx_byte_done_i),
        .err_in(err_in), .idle_det(rx_idle_i),
        .rdrf(flags.rdrf), .idle(flags.idle), .ovr(flags.ovr),
        .err(err_q), .capture(rx_capture_o)
    );

    assign flags.noise = err_q.noise;
    assign flags.ferr  = err_q.ferr;
    assign flags.perr  = err_q.perr;

    ufc_irq_comb u_irq (
        .flags(flags), .en(irq_en_t'(int_en_i)), .mask(irq_mask_i), .irq(irq_o)
    );

    assign status_o = flags;
endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk #(
    parameter int ADDR_W = 1,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              tx_frame_done_i,
    input logic [1:0]        frame_kind_i,
    input logic              rx_byte_done_i,
    input logic              irq_mask_i,
    input logic [7:0]        status_o,
    input logic              load_shifter_o,
    input logic              rx_capture_o,
    input logic              irq_o
);
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (status_o == 8'hC0));

    a_r5_tdre_rises_only_by_load: assert property (@(posedge clk) disable iff (rst)
        (!status_o[7] && !load_shifter_o) |=> !status_o[7]);

    a_r3_tdre_falls_after_write: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[7]) |-> $past(reg_wr_i && reg_addr_i == DATA_ADDR));

    a_r6_no_tc_for_special_frame: assert property (@(posedge clk) disable iff (rst)
        (tx_frame_done_i && frame_kind_i != 2'b00 && !status_o[6]) |=> !status_o[6]);

    a_r7_capture_sets_ready: assert property (@(posedge clk) disable iff (rst)
        rx_capture_o |=> status_o[5]);

    a_r8_overrun_on_full: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_done_i && status_o[5]) |=> (status_o[5] && status_o[3]));

    a_r9_ready_falls_after_read: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[5]) |-> $past(reg_rd_i && reg_addr_i == DATA_ADDR));

    a_r11_mask_blocks_irq: assert property (@(posedge clk) disable iff (rst)
        irq_mask_i |-> !irq_o);

    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (status_o[7:3] == 5'b0 && !status_o[0]) |-> !irq_o);
endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_chk (
    .clk(clk), .rst(rst), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .tx_frame_done_i(tx_frame_done_i),
    .frame_kind_i(frame_kind_i), .rx_byte_done_i(rx_byte_done_i),
    .irq_mask_i(irq_mask_i), .status_o(status_o), .load_shifter_o(load_shifter_o),
    .rx_capture_o(rx_capture_o), .irq_o(irq_o)
);

// File: tb/tb_uart_flag_ctrl.sv
module tb_uart_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_rd_i = 0, reg_wr_i = 0;
    logic [0:0] reg_addr_i = 0;
    logic       tx_idle_i = 0, tx_frame_done_i = 0;
    logic [1:0] frame_kind_i = 0;
    logic       rx_byte_done_i = 0, rx_noise_i = 0, rx_frame_err_i = 0, rx_parity_err_i = 0;
    logic       rx_idle_i = 0;
    logic [4:0] int_en_i = 0;
    logic       irq_mask_i = 0;
    logic [7:0] status_o;
    logic       load_shifter_o, rx_capture_o, irq_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    uart_flag_ctrl dut (
        .clk(clk), .rst(rst), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .tx_idle_i(tx_idle_i), .tx_frame_done_i(tx_frame_done_i),
        .frame_kind_i(frame_kind_i), .rx_byte_done_i(rx_byte_done_i),
        .rx_noise_i(rx_noise_i), .rx_frame_err_i(rx_frame_err_i),
        .rx_parity_err_i(rx_parity_err_i), .rx_idle_i(rx_idle_i),
        .int_en_i(int_en_i), .irq_mask_i(irq_mask_i), .status_o(status_o),
        .load_shifter_o(load_shifter_o), .rx_capture_o(rx_capture_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_reg(logic a);
        reg_rd_i = 1; reg_addr_i = a; tick(); reg_rd_i = 0;
    endtask

    task automatic wr_reg(logic a);
        reg_wr_i = 1; reg_addr_i = a; tick(); reg_wr_i = 0;
    endtask

    task automatic rx_byte(logic n, logic f, logic p, logic exp_cap, string req);
        rx_byte_done_i = 1; rx_noise_i = n; rx_frame_err_i = f; rx_parity_err_i = p;
        #1 check(req, {7'b0, rx_capture_o}, {7'b0, exp_cap});
        tick();
        rx_byte_done_i = 0; rx_noise_i = 0; rx_frame_err_i = 0; rx_parity_err_i = 0;
    endtask

    task automatic frame_done(logic [1:0] k);
        tx_frame_done_i = 1; frame_kind_i = k; tick(); tx_frame_done_i = 0; frame_kind_i = 0;
    endtask

    function automatic logic exp_irq(logic [7:0] st, logic [4:0] en, logic m);
        return !m && ((en[4] && st[7]) || (en[3] && st[6]) || (en[2] && (st[5] || st[3]))
                      || (en[1] && st[4]) || (en[0] && st[0]));
    endfunction

    // R11: every enable pattern and mask value against the held status word
    task automatic irq_sweep(logic [7:0] st);
        for (int e = 0; e < 32; e++) begin
            for (int m = 0; m < 2; m++) begin
                int_en_i = 5'(e); irq_mask_i = m[0];
                #1 check("R11 irq", {7'b0, irq_o}, {7'b0, exp_irq(st, 5'(e), m[0])});
            end
        end
        int_en_i = 0; irq_mask_i = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 0;
        // R1 / R2: reset word has bits 7 and 6 set
        check("R1 reset status", status_o, 8'hC0);
        check("R1 reset irq", {7'b0, irq_o}, 8'h00);

        // R3: data write without a status read first changes nothing
        wr_reg(1'b1);
        check("R3 unarmed write", status_o, 8'hC0);

        // R3: status read then data write clears bits 7 and 6
        rd_reg(1'b0);
        wr_reg(1'b1);
        check("R3 armed write clears tx", status_o, 8'h00);
        check("R5 no load while busy", {7'b0, load_shifter_o}, 8'h00);
        tick();
        check("R5 tdre held while busy", status_o, 8'h00);

        // R5: shifter idle -> load now, tdre next cycle
        tx_idle_i = 1;
        #1 check("R5 load asserted", {7'b0, load_shifter_o}, 8'h01);
        tick();
        check("R5 tdre set after load", status_o, 8'h80);
        check("R5 load drops", {7'b0, load_shifter_o}, 8'h00);
        tx_idle_i = 0;

        // R6: preamble and break frames leave tc clear, data frame sets it
        frame_done(2'b01);
        check("R6 preamble", status_o, 8'h80);
        frame_done(2'b10);
        check("R6 break", status_o, 8'h80);
        frame_done(2'b00);
        check("R6 data frame", status_o, 8'hC0);

        // R4: arming is used up by a data read
        rd_reg(1'b0);
        rd_reg(1'b1);
        wr_reg(1'b1);
        check("R4 arming consumed", status_o, 8'hC0);

        // R7: byte with framing and parity errors
        rx_byte(1'b0, 1'b1, 1'b1, 1'b1, "R7 capture");
        check("R7 rdrf and errors", status_o, 8'hE3);

        // R8: byte while still full
        rx_byte(1'b0, 1'b0, 1'b0, 1'b0, "R8 no capture");
        check("R8 overrun kept errors", status_o, 8'hEB);

        // R12: idle detect
        rx_idle_i = 1; tick(); rx_idle_i = 0;
        check("R12 idle set", status_o, 8'hFB);

        // R9: status read then data read clears receive side
        rd_reg(1'b0);
        rd_reg(1'b1);
        check("R9 rx clear", status_o, 8'hC0);

        // R10: tc set collides with tx clear
        rd_reg(1'b0);
        reg_wr_i = 1; reg_addr_i = 1; tx_frame_done_i = 1; frame_kind_i = 0;
        tick();
        reg_wr_i = 0; tx_frame_done_i = 0;
        check("R10 tc set wins", status_o, 8'h40);

        // R10: rx byte collides with rx clear
        rx_byte(1'b0, 1'b0, 1'b0, 1'b1, "R7 capture empty");
        check("R7 rdrf set", status_o, 8'h60);
        rd_reg(1'b0);
        reg_rd_i = 1; reg_addr_i = 1; rx_byte_done_i = 1;
        tick();
        reg_rd_i = 0; rx_byte_done_i = 0;
        check("R10 rdrf/ovr set wins", status_o, 8'h68);
        rd_reg(1'b0);
        rd_reg(1'b1);
        check("R9 rx clear again", status_o, 8'h40);

        irq_sweep(8'h40);
        rd_reg(1'b0);
        wr_reg(1'b1);
        check("R3 clear to zero", status_o, 8'h00);
        irq_sweep(8'h00);

        // noise and framing only on the receive error side
        rx_byte(1'b1, 1'b1, 1'b0, 1'b1, "R7 capture noisy");
        check("R7 noise framing", status_o, 8'h26);
        irq_sweep(8'h26);

        tx_idle_i = 1; tick(); tx_idle_i = 0;
        check("R5 reload", status_o, 8'hA6);
        rx_idle_i = 1; tick(); rx_idle_i = 0;
        check("R12 idle", status_o, 8'hB6);
        rx_byte(1'b0, 1'b0, 1'b1, 1'b0, "R8 no capture full");
        check("R8 overrun", status_o, 8'hBE);
        frame_done(2'b00);
        check("R6 tc", status_o, 8'hFE);
        irq_sweep(8'hFE);

        finish_run();
    end
endmodule